// File: doc/BRIEF.md
# Line-Clock Power Sequencing Monitor

This block turns a mains-derived line clock into the power-status signals of a backplane bus. The raw line clock is synchronized, glitch-filtered and re-driven as a clean event output. The same filtered edges act as a heartbeat for the mains: when the heartbeat stops for long enough, the block takes the bus down in two steps. First it drops power-ok. After a fixed gap, which must exceed the hold-up time the supply guarantees, it drops DC-ok.

Power-up is ordered as well. DC-ok is raised once the supply-present input is high and the filtered line clock has shown fresh edges. Power-ok then follows after a fixed delay. All delays are parameters in microseconds and are scaled by the number of system clocks per microsecond. No separate power-fail input exists: missing line-clock edges are the only sign of mains loss.

Top module: `linefreq_power_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `evt_o`, `dc_ok_o` and `pwr_ok_o` are all low.
- R2: While `dc_ok_o` is high, an accepted change of `line_raw_i` appears on `evt_o` at the 7th rising clock edge after the input changes: 2 synchronizer stages, 3 filter samples, the level register and the output register.
- R3: A `line_raw_i` level that lasts fewer than `FILT_LEN` (default 3) consecutive synchronized samples is ignored and `evt_o` does not change. A level that lasts exactly `FILT_LEN` samples is accepted.
- R4: From the powered-down state, `dc_ok_o` rises only after `supply_ok_i` is high and at least `MIN_EDGES` (default 2) accepted line-clock transitions of either direction have been seen while `supply_ok_i` was high. `dc_ok_o` rises on the 8th rising edge after the raw change that completes the count. Edges seen while `supply_ok_i` is low do not count.
- R5: `pwr_ok_o` rises exactly `POK_US*CLK_PER_US` cycles after `dc_ok_o` rises.
- R6: While `dc_ok_o` is high, a gap of more than `LOSS_US*CLK_PER_US` cycles without an accepted edge drops `pwr_ok_o` exactly that many cycles after the last `evt_o` change. A gap of exactly that length keeps power, because an edge that arrives in the expiring cycle restarts the timer.
- R7: `dc_ok_o` falls exactly `DROP_US*CLK_PER_US` cycles after the loss is declared. That gap is never shorter than `HOLD_US*CLK_PER_US` cycles.
- R8: Once a loss is declared, the shutdown completes even if line-clock edges return. Power then comes back only through a full power-up: fresh edges, then `dc_ok_o`, then `pwr_ok_o` after the full delay.
- R9: `evt_o` is low whenever `dc_ok_o` is low.
- R10: `pwr_ok_o` is never high while `dc_ok_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, `CLK_PER_US` cycles per microsecond |
| rst_i | input | 1 | Synchronous active-high reset |
| line_raw_i | input | 1 | Raw, asynchronous line-clock level |
| supply_ok_i | input | 1 | High while the DC supply is present |
| evt_o | output | 1 | Cleaned line-clock event signal for the bus |
| dc_ok_o | output | 1 | DC-ok bus status, active high |
| pwr_ok_o | output | 1 | Power-ok bus status, active high |

## Verification
The collision that matters is an accepted line-clock edge that arrives in the same cycle the loss timer reaches its limit. The design must treat that edge as a restart, not as a loss. The bench provokes this by toggling the raw input with a gap of exactly the loss window and then one cycle more. It judges the result by whether `pwr_ok_o` stays high or falls. When it falls, the bench times the fall against the last `evt_o` change. A second overlap is returning edges during the shutdown window. The bench judges that case by the exact DC-ok fall time and by the full-length power-ok delay on the following restart.

// File: rtl/lpsm_pkg.sv
package lpsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RAMP     = 3'd1,
    ST_LIVE     = 3'd2,
    ST_SHED_PWR = 3'd3,
    ST_SHED_DC  = 3'd4
  } seq_st_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lpsm_line_filter.sv
module lpsm_line_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic lvl_o,
  output logic edge_o
);

  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                lvl_q;
  logic                lvl_d;
  logic                edge_q;

  // synchronizer chain, length set by parameter
  generate
    if (SYNC_LEN == 1) begin : g_sync1
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= raw_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[SYNC_LEN-2:0], raw_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) hist_q <= '0;
    else       hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
  end

  always_comb begin
    lvl_d = lvl_q;
    if (&hist_q)       lvl_d = 1'b1;
    else if (~|hist_q) lvl_d = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      edge_q <= lvl_d ^ lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = edge_q;

  // R3
  lvl_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lvl_q) |-> $past(&hist_q));
  // R3
  lvl_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lvl_q) |-> $past(~|hist_q));
  // R2
  edge_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_q |-> (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/lpsm_gap_timer.sv
module lpsm_gap_timer #(
  parameter int CNT_W     = 17,
  parameter int LOSS_CYC  = 50000,
  parameter int MIN_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic edge_i,
  input  logic count_en_i,
  output logic lost_o,
  output logic enough_o
);

  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [CNT_W-1:0] LOSS_LIM = CNT_W'(LOSS_CYC);
  localparam logic [EW-1:0]    EDGE_LIM = EW'(MIN_EDGES);

  logic [CNT_W-1:0] gap_q;
  logic [EW-1:0]    seen_q;

  // cycles since the last accepted edge, restarting at one
  always_ff @(posedge clk_i) begin
    if (rst_i)              gap_q <= '0;
    else if (edge_i)        gap_q <= CNT_W'(1);
    else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !count_en_i)             seen_q <= '0;
    else if (edge_i && seen_q < EDGE_LIM) seen_q <= seen_q + 1'b1;
  end

  assign lost_o   = (gap_q >= LOSS_LIM) && !edge_i;
  assign enough_o = (seen_q >= EDGE_LIM);

  // R4
  enough_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(enough_o) |-> $past(edge_i) && $past(count_en_i));

endmodule

// File: rtl/lpsm_seq_fsm.sv
module lpsm_seq_fsm
  import lpsm_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int POK_CYC  = 72000,
  parameter int DROP_CYC = 4000,
  parameter int HOLD_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic supply_i,
  input  logic enough_i,
  input  logic lost_i,
  input  logic lvl_i,
  output logic count_en_o,
  output logic evt_o,
  output logic dc_ok_o,
  output logic pwr_ok_o
);

  localparam logic [CNT_W-1:0] POK_LAST  = CNT_W'(POK_CYC - 1);
  localparam logic [CNT_W-1:0] DROP_LAST = CNT_W'(DROP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_MIN  = CNT_W'(HOLD_CYC);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] phase_q;
  logic             dc_q, pwr_q, evt_q;
  logic             dc_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (supply_i && enough_i)   st_d = ST_RAMP;
      ST_RAMP:     if (lost_i)                 st_d = ST_SHED_PWR;
                   else if (phase_q == POK_LAST) st_d = ST_LIVE;
      ST_LIVE:     if (lost_i)                 st_d = ST_SHED_PWR;
      ST_SHED_PWR: if (phase_q == DROP_LAST)   st_d = ST_SHED_DC;
      ST_SHED_DC:                              st_d = ST_IDLE;
      default:                                 st_d = ST_IDLE;
    endcase
  end

  assign dc_d = (st_d == ST_RAMP) || (st_d == ST_LIVE) || (st_d == ST_SHED_PWR);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      dc_q    <= 1'b0;
      pwr_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      phase_q <= (st_d != st_q) ? '0 : phase_q + 1'b1;
      dc_q    <= dc_d;
      pwr_q   <= (st_d == ST_LIVE);
      evt_q   <= dc_d & lvl_i;
    end
  end

  assign count_en_o = (st_q == ST_IDLE) && supply_i;
  assign evt_o      = evt_q;
  assign dc_ok_o    = dc_q;
  assign pwr_ok_o   = pwr_q;

  // cycles since power-ok was last high, used only by the hold-up check
  logic [CNT_W-1:0] hold_q;
  always_ff @(posedge clk_i) begin
    if (rst_i || pwr_q)     hold_q <= '0;
    else if (hold_q != '1)  hold_q <= hold_q + 1'b1;
  end

  // R7
  hold_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(dc_q) |-> (hold_q >= HOLD_MIN));
  // R10
  pwr_needs_dc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pwr_q |-> dc_q);
  // R9
  evt_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !dc_q |-> !evt_q);
  // R5
  pwr_after_dc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwr_q) |-> $past(dc_q));
  // R4
  dc_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(dc_q) |-> $past(supply_i) && $past(enough_i));
  // R8
  shed_finish_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_SHED_PWR) |=> (st_q == ST_SHED_PWR) || (st_q == ST_SHED_DC));

endmodule

// File: rtl/linefreq_power_seq.sv
module linefreq_power_seq
  import lpsm_pkg::*;
#(
  parameter int CLK_PER_US = 1,
  parameter int POK_US     = 72000,
  parameter int LOSS_US    = 50000,
  parameter int DROP_US    = 4000,
  parameter int HOLD_US    = 3000,
  parameter int SYNC_LEN   = 2,
  parameter int FILT_LEN   = 3,
  parameter int MIN_EDGES  = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_raw_i,
  input  logic supply_ok_i,
  output logic evt_o,
  output logic dc_ok_o,
  output logic pwr_ok_o
);

  localparam int POK_CYC  = POK_US  * CLK_PER_US;
  localparam int LOSS_CYC = LOSS_US * CLK_PER_US;
  localparam int DROP_CYC = DROP_US * CLK_PER_US;
  localparam int HOLD_CYC = HOLD_US * CLK_PER_US;
  localparam int CNT_W    = $clog2(max_of3(POK_CYC, LOSS_CYC, DROP_CYC) + 2);

  logic lvl, edge_p, lost, enough, count_en;

  lpsm_line_filter #(
    .SYNC_LEN(SYNC_LEN),
    .FILT_LEN(FILT_LEN)
  ) u_filt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .raw_i (line_raw_i),
    .lvl_o (lvl),
    .edge_o(edge_p)
  );

  lpsm_gap_timer #(
    .CNT_W    (CNT_W),
    .LOSS_CYC (LOSS_CYC),
    .MIN_EDGES(MIN_EDGES)
  ) u_gap (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .edge_i    (edge_p),
    .count_en_i(count_en),
    .lost_o    (lost),
    .enough_o  (enough)
  );

  lpsm_seq_fsm #(
    .CNT_W   (CNT_W),
    .POK_CYC (POK_CYC),
    .DROP_CYC(DROP_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .supply_i  (supply_ok_i),
    .enough_i  (enough),
    .lost_i    (lost),
    .lvl_i     (lvl),
    .count_en_o(count_en),
    .evt_o     (evt_o),
    .dc_ok_o   (dc_ok_o),
    .pwr_ok_o  (pwr_ok_o)
  );

  // R6
  loss_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (lost && dc_ok_o) |=> !pwr_ok_o);

endmodule

// File: tb/sim_linefreq_power_seq.sv
module sim_linefreq_power_seq;

  localparam int CLK_NS = 10;
  localparam int T_POK  = 40;
  localparam int T_LOSS = 30;
  localparam int T_DROP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic sup = 1'b0;
  logic evt, dc, pk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  int t_dc_rise = 0, t_dc_fall = 0, t_pk_rise = 0, t_pk_fall = 0;
  int t_evt = 0, t_evt_snap = 0, n_evt = 0, n_pk_rise = 0;
  int v9 = 0, v10 = 0;
  logic dc_p = 1'b0, pk_p = 1'b0, evt_p = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  linefreq_power_seq #(
    .CLK_PER_US(1), .POK_US(T_POK), .LOSS_US(T_LOSS), .DROP_US(T_DROP),
    .HOLD_US(5), .SYNC_LEN(2), .FILT_LEN(3), .MIN_EDGES(2)
  ) u0 (
    .clk_i(clk), .rst_i(rst), .line_raw_i(raw), .supply_ok_i(sup),
    .evt_o(evt), .dc_ok_o(dc), .pwr_ok_o(pk)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (dc && !dc_p) t_dc_rise = cyc;
      if (!dc && dc_p) t_dc_fall = cyc;
      if (pk && !pk_p) begin t_pk_rise = cyc; n_pk_rise++; end
      if (!pk && pk_p) begin t_pk_fall = cyc; t_evt_snap = t_evt; end
      if (evt != evt_p) begin t_evt = cyc; n_evt++; end
      if (evt && !dc) v9++;
      if (pk && !dc)  v10++;
    end
    dc_p = dc; pk_p = pk; evt_p = evt;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tog(input int gap);
    raw = ~raw;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    // R1: outputs low during reset
    check(!evt && !dc && !pk, "R1 in reset", {evt, dc, pk}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!evt && !dc && !pk, "R1 after reset", {evt, dc, pk}, 0);

    // R4: edges with supply low do not count
    for (int i = 0; i < 6; i++) tog(10);
    check(!dc, "R4 supply low", dc, 0);
    sup = 1'b1;
    repeat (60) @(negedge clk);
    check(!dc, "R4 stale edges ignored", dc, 0);
    tog(20);
    check(!dc, "R4 one edge", dc, 0);
    raw = ~raw;
    repeat (7) @(negedge clk);
    check(!dc, "R4 before 8th edge", dc, 0);
    @(negedge clk);
    check(dc, "R4 at 8th edge", dc, 1);

    // R5: power-ok delay, keep the line alive meanwhile
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10 && !pk; i++) tog(10);
    check(pk && (t_pk_rise - t_dc_rise == T_POK), "R5 pok delay",
          t_pk_rise - t_dc_rise, T_POK);

    // R2: event latency, both polarities
    for (int p = 0; p < 2; p++) begin
      raw = ~raw;
      repeat (6) @(negedge clk);
      check(evt != raw, "R2 not before 7th edge", evt, !raw);
      @(negedge clk);
      check(evt == raw, "R2 at 7th edge", evt, raw);
      repeat (5) @(negedge clk);
    end

    // R3: short glitch ignored, minimum width accepted
    n0 = n_evt;
    raw = ~raw; repeat (2) @(negedge clk); raw = ~raw;
    repeat (14) @(negedge clk);
    check(n_evt == n0, "R3 2-sample glitch", n_evt - n0, 0);
    n0 = n_evt;
    raw = ~raw; repeat (3) @(negedge clk); raw = ~raw;
    repeat (14) @(negedge clk);
    check(n_evt == n0 + 2, "R3 3-sample pulse", n_evt - n0, 2);

    // R6: gap sweep up to exactly the loss window keeps power
    for (int g = 4; g <= T_LOSS; g += 2) begin
      for (int k = 0; k < 3; k++) tog(g);
      check(pk, "R6 gap within window", g, 1);
    end

    // R6: one cycle more drops power-ok, R7 timing, R8 edges keep coming
    tog(T_LOSS + 1);
    for (int i = 0; i < 40 && n_pk_rise < 2; i++) tog(10);
    check(t_pk_fall - t_evt_snap == T_LOSS, "R6 loss timing",
          t_pk_fall - t_evt_snap, T_LOSS);
    check(t_dc_fall - t_pk_fall == T_DROP, "R7 dc drop gap",
          t_dc_fall - t_pk_fall, T_DROP);
    check(n_pk_rise == 2, "R8 restart happened", n_pk_rise, 2);
    check(t_pk_rise - t_dc_rise == T_POK, "R8 full pok delay on restart",
          t_pk_rise - t_dc_rise, T_POK);

    // R6: silence takes everything down
    repeat (T_LOSS + T_DROP + 20) @(negedge clk);
    check(!pk && !dc, "R6 silence shutdown", {dc, pk}, 0);
    check(!evt, "R9 event low when down", evt, 0);
    check(v9 == 0, "R9 event gated", v9, 0);
    check(v10 == 0, "R10 pok implies dc", v10, 0);
    finish_run();
  end

endmodule